// File: doc/BRIEF.md
# Multiply/Divide Coprocessor

This block sits beside a 16-bit processor and provides 16×16 multiplication and 32÷32 division, each signed or unsigned. Two 32-bit result registers hold its results. The processor first writes an 8-bit mode word. It then either presents operands or reads results back. One field of the mode word selects the operation. Two other bits choose which result register, and which 16-bit half of it, drives the read port. A 4-bit condition flag vector (carry, overflow, zero, negative) is presented together with the read data.

Multiplication and the initialize load complete at the clock edge that accepts the operand. Division takes its dividend from result register 0 and its divisor from the operand write. A restoring shift/subtract sequencer then runs. It places the quotient in result register 0 and the remainder in result register 1. A busy output stays high while the sequencer runs. Results stay in the registers until an operation replaces them, so the processor can read them back one half at a time, in any order and as often as it needs.

Top module: `muldiv_copro`

## Requirements
- R1: A synchronous active-high reset clears the mode register, both result registers and the flags, and drops busy. After reset, `rd_data` and `flags` read zero.
- R2: The mode word is decoded by fields. Bits 3:0 give the operation: 2 is init, 3 is read-only, 4 is unsigned multiply, 5 is signed multiply, 8 is unsigned divide, 9 is signed divide. Bit 4 selects the upper half. Bit 5 selects result register 1. Bits 7:6 must be zero for an operation to be recognised. `rd_data` always shows the selected half of the selected register, and reading changes nothing, so repeated reads return the same value.
- R3: In init mode, an operand write loads `arg_b` into result register 0 and sets the flags to 0000.
- R4: In unsigned multiply mode (0x04, or 0x14 for the upper half), an operand write stores `arg_a × arg_b[15:0]` as a 32-bit unsigned product in result register 0 at the same edge.
- R5: In signed multiply mode (0x05 or 0x15), the two 16-bit operands are taken as two's complement and the 32-bit signed product goes to result register 0. For both multiply kinds, Z and N follow the product and C and V are 0.
- R6: In unsigned divide mode (0x08), an operand write starts a division of result register 0 by `arg_b`. Busy is high for exactly 33 cycles after the accepting edge. At the edge where busy falls, the quotient is in result register 0 and the remainder is in result register 1.
- R7: In signed divide mode (0x09), the quotient truncates toward zero and a nonzero remainder takes the sign of the dividend. 0x80000000 ÷ 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R8: After a division by a nonzero divisor, the flags are C=0, V=0, Z set when the quotient is zero, and N equal to quotient bit 31. The flag vector order is `flags[3]`=C, `flags[2]`=V, `flags[1]`=Z, `flags[0]`=N.
- R9: Division by zero, signed or unsigned, gives a quotient of 0xFFFFFFFF, a remainder equal to the dividend, and flags 0100 (V set only).
- R10: While busy is high, mode writes and operand writes are ignored.
- R11: An operand write in read-only mode or with an unlisted operation code changes neither result register nor the flags. Only a completed division writes result register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Mode word |
| arg_we | input | 1 | Operand write strobe |
| arg_a | input | 16 | First multiplication operand |
| arg_b | input | 32 | Second multiplication operand (low half), divisor or init value |
| busy | output | 1 | Division in progress |
| rd_data | output | 16 | Selected half of the selected result register |
| flags | output | 4 | Condition flags {C, V, Z, N} |

## Verification
The assertions assume that the strobes are never unknown once reset has been released. They also assume that reset is held for at least one clock edge before the first check. The multiply and init properties assume the operand is sampled at the accepting edge only, with no relation to later bus values. The bench drives every strobe for exactly one cycle on the falling edge and holds reset over several edges at time zero. It also waits for busy to fall before it issues any further traffic, except in the one scenario that deliberately writes during a division.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

    localparam logic [3:0] OPC_INIT = 4'h2;
    localparam logic [3:0] OPC_READ = 4'h3;
    localparam logic [3:0] OPC_MULU = 4'h4;
    localparam logic [3:0] OPC_MULS = 4'h5;
    localparam logic [3:0] OPC_DIVU = 4'h8;
    localparam logic [3:0] OPC_DIVS = 4'h9;

    typedef struct packed {
        logic [1:0] rsv;
        logic       sel_r1;
        logic       sel_hi;
        logic [3:0] opc;
    } mode_t;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
    } flags_t;

    typedef struct packed {
        logic do_init;
        logic do_mul;
        logic do_div;
        logic sgn;
    } opcls_t;

    function automatic opcls_t classify(mode_t m);
        opcls_t r;
        r = '0;
        if (m.rsv == 2'b00) begin
            case (m.opc)
                OPC_INIT: r.do_init = 1'b1;
                OPC_MULU: r.do_mul  = 1'b1;
                OPC_MULS: begin r.do_mul = 1'b1; r.sgn = 1'b1; end
                OPC_DIVU: r.do_div  = 1'b1;
                OPC_DIVS: begin r.do_div = 1'b1; r.sgn = 1'b1; end
                default:  r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/muldiv_mode_dec.sv
`timescale 1ns/1ps
module muldiv_mode_dec
    import muldiv_pkg::*;
(
    input  mode_t  mode_i,
    output opcls_t cls_o,
    output logic   sel_r1_o,
    output logic   sel_hi_o
);
    always_comb begin
        cls_o    = classify(mode_i);
        sel_r1_o = mode_i.sel_r1;
        sel_hi_o = mode_i.sel_hi;
    end
endmodule

// File: rtl/muldiv_divider.sv
`timescale 1ns/1ps
module muldiv_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] quot,
    output logic [W-1:0] rmd
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          busy_q, done_q, neg_q, neg_r, dvz_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  part_q, shq_q, dsr_q, orig_q;
    logic [W:0]    trial;
    logic [W-1:0]  diff;
    logic          fits;

    function automatic logic [W-1:0] magnitude(logic s, logic [W-1:0] x);
        return (s && x[W-1]) ? (~x + 1'b1) : x;
    endfunction

    always_comb begin
        trial = {part_q, shq_q[W-1]};
        fits  = trial >= {1'b0, dsr_q};
        diff  = trial[W-1:0] - dsr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            part_q <= '0;
            shq_q  <= '0;
            dsr_q  <= '0;
            orig_q <= '0;
            neg_q  <= 1'b0;
            neg_r  <= 1'b0;
            dvz_q  <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= '0;
            part_q <= '0;
            shq_q  <= magnitude(sgn, dividend);
            dsr_q  <= magnitude(sgn, divisor);
            orig_q <= dividend;
            neg_q  <= sgn && (dividend[W-1] ^ divisor[W-1]);
            neg_r  <= sgn && dividend[W-1];
            dvz_q  <= (divisor == '0);
        end else if (busy_q && !done_q) begin
            part_q <= fits ? diff : trial[W-1:0];
            shq_q  <= {shq_q[W-2:0], fits};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST) done_q <= 1'b1;
        end else if (done_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end
    end

    always_comb begin
        busy     = busy_q;
        done     = done_q;
        div_zero = dvz_q;
        if (dvz_q) begin
            quot = '1;
            rmd  = orig_q;
        end else begin
            quot = neg_q ? (~shq_q + 1'b1) : shq_q;
            rmd  = neg_r ? (~part_q + 1'b1) : part_q;
        end
    end
endmodule

// File: rtl/muldiv_outsel.sv
`timescale 1ns/1ps
module muldiv_outsel #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] res0,
    input  logic [2*HALF_W-1:0] res1,
    input  logic                sel_r1,
    input  logic                sel_hi,
    output logic [HALF_W-1:0]   data
);
    logic [2*HALF_W-1:0] word;
    always_comb begin
        word = sel_r1 ? res1 : res0;
        data = sel_hi ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];
    end
endmodule

// File: rtl/muldiv_copro.sv
`timescale 1ns/1ps
module muldiv_copro
    import muldiv_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_we,
    input  logic [7:0]          mode_wdata,
    input  logic                arg_we,
    input  logic [HALF_W-1:0]   arg_a,
    input  logic [2*HALF_W-1:0] arg_b,
    output logic                busy,
    output logic [HALF_W-1:0]   rd_data,
    output logic [3:0]          flags
);
    localparam int FULL_W = 2 * HALF_W;

    mode_t              mode_q;
    flags_t             flg_q;
    logic [FULL_W-1:0]  res0_q, res1_q;
    opcls_t             cls;
    logic               sel_r1, sel_hi;
    logic               div_busy, div_done, div_zero;
    logic [FULL_W-1:0]  quot, rmd, prod, ext_a, ext_b;
    logic               accept;

    muldiv_mode_dec u_dec (
        .mode_i   (mode_q),
        .cls_o    (cls),
        .sel_r1_o (sel_r1),
        .sel_hi_o (sel_hi)
    );

    muldiv_divider #(.W(FULL_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && cls.do_div),
        .sgn      (cls.sgn),
        .dividend (res0_q),
        .divisor  (arg_b),
        .busy     (div_busy),
        .done     (div_done),
        .div_zero (div_zero),
        .quot     (quot),
        .rmd      (rmd)
    );

    muldiv_outsel #(.HALF_W(HALF_W)) u_sel (
        .res0   (res0_q),
        .res1   (res1_q),
        .sel_r1 (sel_r1),
        .sel_hi (sel_hi),
        .data   (rd_data)
    );

    always_comb begin
        accept = arg_we && !div_busy;
        ext_a  = {{HALF_W{cls.sgn & arg_a[HALF_W-1]}}, arg_a};
        ext_b  = {{HALF_W{cls.sgn & arg_b[HALF_W-1]}}, arg_b[HALF_W-1:0]};
        prod   = ext_a * ext_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            flg_q  <= '0;
            res0_q <= '0;
            res1_q <= '0;
        end else begin
            if (mode_we && !div_busy) mode_q <= mode_t'(mode_wdata);
            if (accept && cls.do_init) begin
                res0_q <= arg_b;
                flg_q  <= '0;
            end
            if (accept && cls.do_mul) begin
                res0_q <= prod;
                flg_q  <= '{c: 1'b0, v: 1'b0, z: (prod == '0), n: prod[FULL_W-1]};
            end
            if (div_done) begin
                res0_q <= quot;
                res1_q <= rmd;
                if (div_zero) flg_q <= '{c: 1'b0, v: 1'b1, z: 1'b0, n: 1'b0};
                else          flg_q <= '{c: 1'b0, v: 1'b0, z: (quot == '0), n: quot[FULL_W-1]};
            end
        end
    end

    always_comb begin
        busy  = div_busy;
        flags = flg_q;
    end
endmodule

// File: rtl/muldiv_copro_chk.sv
`timescale 1ns/1ps
module muldiv_copro_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                arg_we,
    input logic [HALF_W-1:0]   arg_a,
    input logic [2*HALF_W-1:0] arg_b,
    input logic                busy,
    input logic [7:0]          mode,
    input logic [2*HALF_W-1:0] res0,
    input logic [2*HALF_W-1:0] res1,
    input logic [3:0]          flags
);
    localparam int FULL_W = 2 * HALF_W;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (res0 == '0 && res1 == '0 && !busy && flags == 4'h0 && mode == 8'h00));

    a_r3_init_load: assert property (@(posedge clk) disable iff (rst)
        (arg_we && !busy && mode == 8'h02) |=> (res0 == $past(arg_b) && flags == 4'h0));

    a_r4_mul_unsigned: assert property (@(posedge clk) disable iff (rst)
        (arg_we && !busy && mode[7:6] == 2'b00 && mode[3:0] == 4'h4)
        |=> res0 == FULL_W'(FULL_W'($past(arg_a)) * FULL_W'($past(arg_b[HALF_W-1:0]))));

    a_r6_div_starts_busy: assert property (@(posedge clk) disable iff (rst)
        (arg_we && !busy && mode[7:6] == 2'b00 && (mode[3:0] == 4'h8 || mode[3:0] == 4'h9))
        |=> busy);

    a_r8_div_carry_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !flags[3]);

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode));

    a_r11_res1_by_div_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(res1) |-> $past(busy));
endmodule

bind muldiv_copro muldiv_copro_chk #(.HALF_W(HALF_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .arg_we (arg_we),
    .arg_a  (arg_a),
    .arg_b  (arg_b),
    .busy   (busy),
    .mode   (mode_q),
    .res0   (res0_q),
    .res1   (res1_q),
    .flags  (flags)
);

// File: tb/muldiv_copro_test.sv
`timescale 1ns/1ps
module muldiv_copro_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        arg_we = 1'b0;
    logic [15:0] arg_a = '0;
    logic [31:0] arg_b = '0;
    logic        busy;
    logic [15:0] rd_data;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    muldiv_copro uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .arg_we(arg_we), .arg_a(arg_a), .arg_b(arg_b),
        .busy(busy), .rd_data(rd_data), .flags(flags)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic [7:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic write_arg(logic [15:0] a, logic [31:0] b);
        @(negedge clk); arg_we = 1'b1; arg_a = a; arg_b = b;
        @(negedge clk); arg_we = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy === 1'b1 && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    // Loads dividend, divides, checks busy length, flags and all four halves.
    task automatic run_div(string tag, logic [31:0] dd, logic [31:0] ds, bit sgn,
                           logic [31:0] eq, logic [31:0] er, logic [3:0] ef);
        int n;
        set_mode(8'h02);
        write_arg(16'h0, dd);
        set_mode(sgn ? 8'h09 : 8'h08);
        write_arg(16'h0, ds);
        wait_idle(n);
        chk({tag, " R6 busy cycles"}, 32'(n), 32'd33);
        chk({tag, " R8 flags"}, {28'h0, flags}, {28'h0, ef});
        chk({tag, " R6 quotient low"}, {16'h0, rd_data}, {16'h0, eq[15:0]});
        set_mode(8'h13);
        chk({tag, " R2 quotient high"}, {16'h0, rd_data}, {16'h0, eq[31:16]});
        set_mode(8'h23);
        chk({tag, " R6 remainder low"}, {16'h0, rd_data}, {16'h0, er[15:0]});
        set_mode(8'h33);
        chk({tag, " R6 remainder high"}, {16'h0, rd_data}, {16'h0, er[31:16]});
    endtask

    task automatic t_reset();
        chk("R1 rd_data after reset", {16'h0, rd_data}, 32'h0);
        chk("R1 flags after reset", {28'h0, flags}, 32'h0);
        chk("R1 busy after reset", {31'h0, busy}, 32'h0);
        set_mode(8'h33);
        chk("R1 res1 high after reset", {16'h0, rd_data}, 32'h0);
    endtask

    task automatic t_init();
        set_mode(8'h02);
        write_arg(16'hFFFF, 32'h1234_5678);
        chk("R3 init low", {16'h0, rd_data}, 32'h5678);
        chk("R3 init flags", {28'h0, flags}, 32'h0);
        set_mode(8'h13);
        chk("R2 read high", {16'h0, rd_data}, 32'h1234);
        set_mode(8'h13);
        chk("R2 repeated read", {16'h0, rd_data}, 32'h1234);
        set_mode(8'h03);
        chk("R2 read low", {16'h0, rd_data}, 32'h5678);
        set_mode(8'h42);
        write_arg(16'h0, 32'hCAFE_F00D);
        chk("R2 reserved bits block init", {16'h0, rd_data}, 32'h5678);
    endtask

    task automatic t_mul();
        set_mode(8'h04);
        write_arg(16'hFFFF, 32'hABCD_FFFF);
        chk("R4 unsigned low", {16'h0, rd_data}, 32'h0001);
        chk("R5 unsigned flags N", {28'h0, flags}, 32'h1);
        set_mode(8'h14);
        write_arg(16'd300, 32'd500);
        chk("R4 unsigned high", {16'h0, rd_data}, 32'h0002);
        set_mode(8'h03);
        chk("R4 unsigned low 300x500", {16'h0, rd_data}, 32'h49F0);
        set_mode(8'h05);
        write_arg(16'hFFFD, 32'h0000_0005);
        chk("R5 signed low", {16'h0, rd_data}, 32'hFFF1);
        chk("R5 signed flags", {28'h0, flags}, 32'h1);
        set_mode(8'h15);
        write_arg(16'h8000, 32'h0000_8000);
        chk("R5 signed high", {16'h0, rd_data}, 32'h4000);
        chk("R5 signed flags positive", {28'h0, flags}, 32'h0);
        set_mode(8'h05);
        write_arg(16'h0000, 32'h0000_7FFF);
        chk("R5 zero product flags", {28'h0, flags}, 32'h2);
    endtask

    task automatic t_div();
        run_div("udiv 100/7", 32'd100, 32'd7, 1'b0, 32'd14, 32'd2, 4'h0);
        run_div("udiv 5/9", 32'd5, 32'd9, 1'b0, 32'd0, 32'd5, 4'h2);
        run_div("udiv max/1", 32'hFFFF_FFFF, 32'd1, 1'b0, 32'hFFFF_FFFF, 32'd0, 4'h1);
        run_div("udiv large", 32'hF000_0000, 32'h0001_0001, 1'b0, 32'h0000_EFFF, 32'h0000_1001, 4'h0);
        run_div("R7 sdiv -7/2", 32'hFFFF_FFF9, 32'd2, 1'b1, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 4'h1);
        run_div("R7 sdiv 7/-2", 32'd7, 32'hFFFF_FFFE, 1'b1, 32'hFFFF_FFFD, 32'd1, 4'h1);
        run_div("R7 sdiv -8/-3", 32'hFFFF_FFF8, 32'hFFFF_FFFD, 1'b1, 32'd2, 32'hFFFF_FFFE, 4'h0);
        run_div("R7 sdiv min/-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000, 32'd0, 4'h1);
        run_div("R9 udiv by zero", 32'h0000_1234, 32'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1234, 4'h4);
        run_div("R9 sdiv by zero", 32'hFFFF_FFFB, 32'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 4'h4);
    endtask

    task automatic t_busy_ignore();
        int n;
        set_mode(8'h02);
        write_arg(16'h0, 32'd1000);
        set_mode(8'h08);
        write_arg(16'h0, 32'd7);
        set_mode(8'h23);
        write_arg(16'h0, 32'd3);
        wait_idle(n);
        chk("R10 mode write ignored while busy", {16'h0, rd_data}, 32'd142);
        set_mode(8'h23);
        chk("R10 operand write ignored while busy", {16'h0, rd_data}, 32'd6);
    endtask

    task automatic t_ignored();
        set_mode(8'h03);
        write_arg(16'h1111, 32'hDEAD_BEEF);
        chk("R11 read mode keeps res0", {16'h0, rd_data}, 32'd142);
        chk("R11 read mode keeps flags", {28'h0, flags}, 32'h0);
        set_mode(8'h07);
        write_arg(16'h2222, 32'hBEEF_DEAD);
        set_mode(8'h13);
        chk("R11 unlisted op keeps res0", {16'h0, rd_data}, 32'h0);
        set_mode(8'h02);
        write_arg(16'h0, 32'hAAAA_5555);
        set_mode(8'h23);
        chk("R11 init keeps res1", {16'h0, rd_data}, 32'd6);
        set_mode(8'h04);
        write_arg(16'd2, 32'd3);
        set_mode(8'h33);
        chk("R11 multiply keeps res1", {16'h0, rd_data}, 32'h0);
        set_mode(8'h03);
        chk("R4 product readable after", {16'h0, rd_data}, 32'd6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init();
        t_mul();
        t_div();
        t_busy_ignore();
        t_ignored();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule